// File: doc/BRIEF.md
# Set-Associative Branch Target Predictor

This block predicts the outcome and destination of branches for an instruction fetch unit. Fetch presents the address of a branch on the lookup port. In the same cycle the block answers with three values: whether the address is held in its table, whether the branch is predicted taken, and the stored destination address. When a branch resolves later in the pipeline, the resolving stage reports the branch address, the actual direction and the actual destination on the update port. The block then adjusts the table on the next clock edge.

The table has 64 sets of four ways, 256 entries in all. Each entry holds a valid flag, an address tag, a destination address and a two-bit saturating direction counter. A branch gets an entry only once it has actually been taken, and a new entry starts strongly taken. Later outcomes move its counter one step at a time. Within a full set, a three-bit tree per set picks the way to replace.

Top module: `btb_predictor`

## Requirements
- R1: After synchronous reset every entry is invalid, so every lookup reports lk_hit=0, lk_taken=0 and lk_target=0.
- R2: When lk_valid is 0, or the lookup address matches no valid entry, the outputs are lk_hit=0, lk_taken=0 and lk_target=0.
- R3: A taken update whose address misses allocates an entry with direction counter 2'b11. From the next cycle, a lookup of that address gives lk_hit=1, lk_taken=1 and lk_target equal to the reported destination.
- R4: A not-taken update whose address misses changes nothing: the address still misses afterwards, and no other entry of the set is lost.
- R5: The direction counter saturates. A taken update on a hit moves it one step toward 2'b11 and a not-taken update moves it one step toward 2'b00. Values 2'b11 and 2'b10 predict taken, while 2'b01 and 2'b00 predict not taken.
- R6: A taken update that hits replaces the stored destination with the reported one. A not-taken update that hits keeps the stored destination.
- R7: The set index is address bits [7:2] and the tag is bits [31:8]. Bits [1:0] are ignored, so addresses that differ only there share one entry.
- R8: On allocation, an invalid way of the set is used first, taking the lowest-numbered invalid way.
- R9: In a full set the victim comes from a per-set tree p[2:0]. If p[0]=0 the victim is way p[1] (way 0 or 1); if p[0]=1 it is way 2+p[2]. Every update that writes a way points the tree away from that way. Writing way 0 or 1 sets p[0]=1 and p[1]=(way==0). Writing way 2 or 3 sets p[0]=0 and p[2]=(way==2). Reset clears p to 0.
- R10: An update becomes visible to lookups from the cycle after it is presented. A lookup in the same cycle sees the table as it was before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Branch fetch address to look up |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | 32 | Predicted destination (0 on miss) |
| up_valid | input | 1 | Resolved branch report |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Branch was actually taken |
| up_target | input | 32 | Actual destination of the branch |

## Verification
The hardest situation to reach from the ports is replacement in a full set. The tree bits cannot be seen directly, so they show up only as which one of four resident branches disappears when a fifth arrives. To get there, directed sequences fill one set and then touch chosen ways. After that they allocate new tags and check which of the older addresses now miss. A random phase draws addresses from six tags and four sets, which keeps sets overflowing. A bench model of the counters and the tree predicts every lookup.

// File: rtl/btb_pkg.sv
package btb_pkg;

    parameter int ADDR_W  = 32;
    parameter int ALIGN_W = 2;
    parameter int SETS    = 64;
    parameter int WAYS    = 4;

    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - ALIGN_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TREE_W = WAYS - 1;

    typedef logic [1:0]        ctr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [TREE_W-1:0] tree_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam ctr_t CTR_MAX  = 2'b11;
    localparam ctr_t CTR_MIN  = 2'b00;
    localparam ctr_t CTR_SEED = CTR_MAX;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        addr_t target;
        ctr_t  ctr;
    } entry_t;

    function automatic idx_t set_of(input addr_t pc);
        return pc[ALIGN_W +: IDX_W];
    endfunction

    function automatic tag_t tag_of(input addr_t pc);
        return pc[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        if (taken) return (c == CTR_MAX) ? c : c + 2'd1;
        else       return (c == CTR_MIN) ? c : c - 2'd1;
    endfunction

    function automatic logic ctr_says_taken(input ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/btb_set_match.sv
module btb_set_match
    import btb_pkg::*;
(
    input  logic [WAYS-1:0]            valid_vec,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  tag_t                       probe,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit,
    output way_t                       hit_way
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_vec[w] && (tags[w] == probe);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = way_t'(w);
        end
    end
endmodule

// File: rtl/btb_victim_sel.sv
module btb_victim_sel
    import btb_pkg::*;
(
    input  logic [WAYS-1:0] valid_vec,
    input  tree_t           tree,
    output way_t            victim
);
    way_t tree_way;
    way_t free_way;
    logic any_free;

    always_comb begin
        tree_way = tree[0] ? (tree[2] ? way_t'(3) : way_t'(2))
                           : (tree[1] ? way_t'(1) : way_t'(0));
    end

    always_comb begin
        free_way = '0;
        any_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                free_way = way_t'(w);
                any_free = 1'b1;
            end
        end
    end

    assign victim = any_free ? free_way : tree_way;
endmodule

// File: rtl/btb_tree_touch.sv
module btb_tree_touch
    import btb_pkg::*;
(
    input  tree_t cur,
    input  way_t  way,
    output tree_t nxt
);
    always_comb begin
        nxt = cur;
        if (way[1] == 1'b0) begin
            nxt[0] = 1'b1;
            nxt[1] = (way[0] == 1'b0);
        end else begin
            nxt[0] = 1'b0;
            nxt[2] = (way[0] == 1'b0);
        end
    end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [ADDR_W-1:0] lk_target,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);
    entry_t tbl_q  [SETS][WAYS];
    tree_t  tree_q [SETS];

    // lookup path
    idx_t                       lk_set;
    logic [WAYS-1:0]            lk_vvec;
    logic [WAYS-1:0][TAG_W-1:0] lk_tags;
    logic [WAYS-1:0]            lk_hvec;
    logic                       lk_match;
    way_t                       lk_way;
    entry_t                     lk_ent;

    assign lk_set = set_of(lk_pc);

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_vvec[w] = tbl_q[lk_set][w].valid;
            lk_tags[w] = tbl_q[lk_set][w].tag;
        end
    end

    btb_set_match u_lk_match (
        .valid_vec (lk_vvec),
        .tags      (lk_tags),
        .probe     (tag_of(lk_pc)),
        .hit_vec   (lk_hvec),
        .hit       (lk_match),
        .hit_way   (lk_way)
    );

    assign lk_ent    = tbl_q[lk_set][lk_way];
    assign lk_hit    = lk_valid && lk_match;
    assign lk_taken  = lk_hit && ctr_says_taken(lk_ent.ctr);
    assign lk_target = lk_hit ? lk_ent.target : '0;

    // update path
    idx_t                       up_set;
    logic [WAYS-1:0]            up_vvec;
    logic [WAYS-1:0][TAG_W-1:0] up_tags;
    logic [WAYS-1:0]            up_hvec;
    logic                       up_hit;
    way_t                       up_way;
    way_t                       vict_way;
    way_t                       wr_way;
    tree_t                      tree_nxt;
    entry_t                     old_ent;
    entry_t                     new_ent;
    logic                       do_write;

    assign up_set = set_of(up_pc);

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            up_vvec[w] = tbl_q[up_set][w].valid;
            up_tags[w] = tbl_q[up_set][w].tag;
        end
    end

    btb_set_match u_up_match (
        .valid_vec (up_vvec),
        .tags      (up_tags),
        .probe     (tag_of(up_pc)),
        .hit_vec   (up_hvec),
        .hit       (up_hit),
        .hit_way   (up_way)
    );

    btb_victim_sel u_victim (
        .valid_vec (up_vvec),
        .tree      (tree_q[up_set]),
        .victim    (vict_way)
    );

    assign wr_way   = up_hit ? up_way : vict_way;
    assign do_write = up_valid && (up_hit || up_taken);
    assign old_ent  = tbl_q[up_set][up_way];

    btb_tree_touch u_touch (
        .cur (tree_q[up_set]),
        .way (wr_way),
        .nxt (tree_nxt)
    );

    always_comb begin
        if (up_hit) begin
            new_ent        = old_ent;
            new_ent.ctr    = ctr_step(old_ent.ctr, up_taken);
            new_ent.target = up_taken ? up_target : old_ent.target;
        end else begin
            new_ent.valid  = 1'b1;
            new_ent.tag    = tag_of(up_pc);
            new_ent.target = up_target;
            new_ent.ctr    = CTR_SEED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                tree_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) tbl_q[s][w] <= '0;
            end
        end else if (do_write) begin
            tbl_q[up_set][wr_way] <= new_ent;
            tree_q[up_set]        <= tree_nxt;
        end
    end

    // checks
    p_miss_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (!lk_taken && lk_target == '0));

    p_single_match_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hvec) && $onehot0(up_hvec));

    p_nt_miss_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_taken && !up_hit) |=> (tree_q[$past(up_set)] == $past(tree_q[up_set])));

    p_alloc_valid_r3: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_taken && !up_hit) |=>
            (tbl_q[$past(up_set)][$past(vict_way)].valid &&
             tbl_q[$past(up_set)][$past(vict_way)].ctr == CTR_SEED));

    p_ctr_up_r5: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_hit && up_taken) |=>
            (tbl_q[$past(up_set)][$past(up_way)].ctr >= $past(old_ent.ctr)));

    p_ctr_down_r5: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_hit && !up_taken) |=>
            (tbl_q[$past(up_set)][$past(up_way)].ctr <= $past(old_ent.ctr)));

    p_fill_free_r8: assert property (@(posedge clk) disable iff (rst)
        !(&up_vvec) |-> !up_vvec[vict_way]);
endmodule

// File: tb/btb_predictor_tb.sv
module btb_predictor_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid, up_valid, up_taken;
    logic [31:0] lk_pc, up_pc, up_target;
    logic        lk_hit, lk_taken;
    logic [31:0] lk_target;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    btb_predictor u_dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_pc(lk_pc),
        .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
        .up_valid(up_valid), .up_pc(up_pc),
        .up_taken(up_taken), .up_target(up_target)
    );

    // reference model built from the requirements
    logic        m_valid [64][4];
    logic [23:0] m_tag   [64][4];
    logic [31:0] m_tgt   [64][4];
    logic [1:0]  m_ctr   [64][4];
    logic [2:0]  m_tree  [64];

    function automatic logic [31:0] mk(input logic [23:0] t, input logic [5:0] s, input logic [1:0] lo);
        return {t, s, lo};
    endfunction

    task automatic m_clear();
        for (int s = 0; s < 64; s++) begin
            m_tree[s] = 3'b000;
            for (int w = 0; w < 4; w++) begin
                m_valid[s][w] = 1'b0; m_tag[s][w] = '0; m_tgt[s][w] = '0; m_ctr[s][w] = '0;
            end
        end
    endtask

    function automatic int m_find(input logic [31:0] pc);
        for (int w = 0; w < 4; w++)
            if (m_valid[pc[7:2]][w] && m_tag[pc[7:2]][w] == pc[31:8]) return w;
        return -1;
    endfunction

    task automatic m_touch(input int s, input int w);
        if (w < 2) begin m_tree[s][0] = 1'b1; m_tree[s][1] = (w == 0); end
        else       begin m_tree[s][0] = 1'b0; m_tree[s][2] = (w == 2); end
    endtask

    task automatic m_update(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
        int s = int'(pc[7:2]);
        int w = m_find(pc);
        if (w >= 0) begin
            if (tk) begin
                if (m_ctr[s][w] != 2'b11) m_ctr[s][w] = m_ctr[s][w] + 2'd1;
                m_tgt[s][w] = tg;
            end else if (m_ctr[s][w] != 2'b00) m_ctr[s][w] = m_ctr[s][w] - 2'd1;
            m_touch(s, w);
        end else if (tk) begin
            w = -1;
            for (int k = 3; k >= 0; k--) if (!m_valid[s][k]) w = k;
            if (w < 0) w = m_tree[s][0] ? (m_tree[s][2] ? 3 : 2) : (m_tree[s][1] ? 1 : 0);
            m_valid[s][w] = 1'b1; m_tag[s][w] = pc[31:8];
            m_tgt[s][w] = tg; m_ctr[s][w] = 2'b11;
            m_touch(s, w);
        end
    endtask

    task automatic compare(input string req, input logic eh, input logic et, input logic [31:0] eg);
        checks++;
        if (lk_hit !== eh || lk_taken !== et || lk_target !== eg) begin
            errors++;
            $display("FAIL %s pc=%h actual hit=%b taken=%b target=%h expected hit=%b taken=%b target=%h",
                     req, lk_pc, lk_hit, lk_taken, lk_target, eh, et, eg);
        end
    endtask

    task automatic compare_model(input string req);
        int w = lk_valid ? m_find(lk_pc) : -1;
        if (w < 0) compare(req, 1'b0, 1'b0, 32'h0);
        else compare(req, 1'b1, m_ctr[lk_pc[7:2]][w][1], m_tgt[lk_pc[7:2]][w]);
    endtask

    // one cycle: drive at negedge, check lookup, clock in update
    task automatic cyc(input logic lv, input logic [31:0] lp,
                       input logic uv, input logic [31:0] upc, input logic ut, input logic [31:0] utg,
                       input string req, input bit use_model,
                       input logic eh, input logic et, input logic [31:0] eg);
        @(negedge clk);
        lk_valid = lv; lk_pc = lp;
        up_valid = uv; up_pc = upc; up_taken = ut; up_target = utg;
        #1;
        if (use_model) compare_model(req); else compare(req, eh, et, eg);
        @(posedge clk);
        if (uv) m_update(upc, ut, utg);
    endtask

    task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
        cyc(1'b0, 32'h0, 1'b1, pc, tk, tg, "R2", 1'b0, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic look(input logic [31:0] pc, input string req,
                        input logic eh, input logic et, input logic [31:0] eg);
        cyc(1'b1, pc, 1'b0, 32'h0, 1'b0, 32'h0, req, 1'b0, eh, et, eg);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] tg_pool [6];
        logic [5:0]  st_pool [4];
        logic [31:0] a0, a1, a2, a3, a4, a5;
        void'($urandom(32'd1357));
        m_clear();
        rst = 1'b1; lk_valid = 0; lk_pc = 0; up_valid = 0; up_pc = 0; up_taken = 0; up_target = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        a0 = mk(24'h00A001, 6'd9, 2'b00); a1 = mk(24'h00A002, 6'd9, 2'b00);
        a2 = mk(24'h00A003, 6'd9, 2'b00); a3 = mk(24'h00A004, 6'd9, 2'b00);
        a4 = mk(24'h00A005, 6'd9, 2'b00); a5 = mk(24'h00A006, 6'd9, 2'b00);

        look(a0, "R1", 1'b0, 1'b0, 32'h0);
        upd(a0, 1'b0, 32'h1111);                         // R4 not-taken miss
        look(a0, "R4", 1'b0, 1'b0, 32'h0);
        // R10: allocation and same-cycle lookup
        cyc(1'b1, a0, 1'b1, a0, 1'b1, 32'h1000, "R10", 1'b0, 1'b0, 1'b0, 32'h0);
        look(a0, "R3", 1'b1, 1'b1, 32'h1000);
        look(a0 | 32'h3, "R7", 1'b1, 1'b1, 32'h1000);
        cyc(1'b0, a0, 1'b0, 0, 1'b0, 0, "R2", 1'b0, 1'b0, 1'b0, 32'h0);
        // R5 counter walk
        upd(a0, 1'b0, 32'h9999); look(a0, "R5", 1'b1, 1'b1, 32'h1000);
        upd(a0, 1'b0, 32'h9999); look(a0, "R5", 1'b1, 1'b0, 32'h1000);
        upd(a0, 1'b0, 32'h9999); upd(a0, 1'b0, 32'h9999);
        look(a0, "R5", 1'b1, 1'b0, 32'h1000);
        upd(a0, 1'b1, 32'h1000); look(a0, "R5", 1'b1, 1'b0, 32'h1000);
        upd(a0, 1'b1, 32'h2000); look(a0, "R6", 1'b1, 1'b1, 32'h2000);
        // R8: fill remaining ways of set 9
        upd(a1, 1'b1, 32'h3001); upd(a2, 1'b1, 32'h3002); upd(a3, 1'b1, 32'h3003);
        look(a0, "R8", 1'b1, 1'b1, 32'h2000);
        look(a1, "R8", 1'b1, 1'b1, 32'h3001);
        look(a3, "R8", 1'b1, 1'b1, 32'h3003);
        // R9: set full, tree points at way 0 (a0)
        upd(a4, 1'b1, 32'h3004);
        look(a0, "R9", 1'b0, 1'b0, 32'h0);
        look(a4, "R9", 1'b1, 1'b1, 32'h3004);
        upd(a1, 1'b1, 32'h3001);                         // touch way 1 -> right side next
        upd(a5, 1'b1, 32'h3005);                         // evicts way 2 (a2)
        look(a2, "R9", 1'b0, 1'b0, 32'h0);
        look(a3, "R9", 1'b1, 1'b1, 32'h3003);
        look(a5, "R9", 1'b1, 1'b1, 32'h3005);

        // random phase against the model
        for (int i = 0; i < 6; i++) tg_pool[i] = 24'h00C100 + 24'(i * 24'h0417);
        st_pool[0] = 6'd5; st_pool[1] = 6'd6; st_pool[2] = 6'd40; st_pool[3] = 6'd63;
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] lp, upc;
            lp  = mk(tg_pool[$urandom % 6], st_pool[$urandom % 4], 2'($urandom));
            upc = mk(tg_pool[$urandom % 6], st_pool[$urandom % 4], 2'($urandom));
            if ($urandom % 5 == 0) lp = upc;
            cyc(($urandom % 10) != 0, lp, ($urandom % 5) != 0, upc, ($urandom % 10) < 6,
                $urandom, "R5", 1'b1, 1'b0, 1'b0, 32'h0);
        end

        // R1 again after a second reset
        @(negedge clk); rst = 1'b1; up_valid = 1'b0;
        @(posedge clk); m_clear();
        @(negedge clk); rst = 1'b0;
        look(a5, "R1", 1'b0, 1'b0, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule